// File: doc/BRIEF.md
# Eight-Bit Single-Cycle Microcontroller Core

This block is a small 8-bit processor that completes one instruction on every clock edge. Instructions are 16 bits wide and come from a writable store of 32 words. Data lives in eight 8-bit registers. The register file has two read ports and one write port, so the source and destination of an instruction can be read in the same cycle.

The instruction set has seven operations:
- register copy and literal load;
- add and subtract, which update a carry flag;
- a relative branch that is taken only when carry is set;
- a read of an 8-bit input port;
- a write to a registered 8-bit output port.

There is no jump and no compare. A loop that always repeats is built by subtracting a larger value from a smaller one, which sets carry, and then branching.

Software loads the program while the core is held in reset, using a simple write interface. The program counter is brought out to a port so that it can be observed. Reset is asynchronous and active-low. The release of reset passes through a two-stage synchronizer before the core starts fetching at address 0.

Top module: `mcu8_core`

## Requirements
- R1: While rst_n is low, pc_obs, dout, carry and all eight registers are 0. After rst_n rises, the instruction at address 0 executes on the third rising clock edge. pc_obs stays 0 until that edge.
- R2: While the core is not running (rst_n low, or the synchronizer not yet released), a rising edge with load_en high writes load_word into word load_addr. Load writes made while the core is running have no effect on the stored program.
- R3: The fields of an instruction word are:

  | Bits | Field |
  |---|---|
  | [15:13] | opcode: 0 copy, 1 literal load, 2 add, 3 subtract, 4 branch-on-carry, 5 input, 6 output, 7 no operation |
  | [12:10] | destination register |
  | [9:7] | source register |
  | [7:0] | literal |
  | [4:0] | two's-complement branch offset |

  The all-zero word (copy r0 to r0) acts as a no-operation.
- R4: Copy writes the source register into the destination register. Literal load writes the literal. Input writes din. All three take effect at the executing edge.
- R5: Add writes dst+src (mod 256) to the destination and sets carry to the unsigned overflow out of bit 7.
- R6: Subtract writes dst−src (mod 256) to the destination and sets carry to 1 exactly when src > dst.
- R7: A branch with carry set loads pc+1+offset (mod 32). With carry clear the pc advances by 1.
- R8: Only add and subtract change carry. Every other opcode leaves it unchanged.
- R9: Output loads the source register into dout at the executing edge. dout holds its value until the next output instruction.
- R10: Every non-taken instruction advances pc_obs by 1. Address 31 wraps to 0, so bit 0 of the pc toggles on every clock of straight-line code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Program store write enable (honoured only while held) |
| load_addr | input | 5 | Program store write address |
| load_word | input | 16 | Instruction word to write |
| din | input | 8 | Input port sampled by the input instruction |
| dout | output | 8 | Registered output port |
| pc_obs | output | 5 | Current program counter |

## Verification
The checker assumes that rst_n is the only thing that stops execution. Once the synchronizer has released, every cycle is treated as an executed instruction, and no stall or gating of the clock is expected. It also assumes that the program store only changes between reset and run. The stimulus respects this: programs are loaded only with rst_n low, and the single load attempted during execution is there to show that it is ignored. All branch offsets used stay within the 5-bit signed range, and din changes only at falling edges, away from the edge where an input instruction samples it.

// File: rtl/mcu8_pkg.sv
package mcu8_pkg;
  parameter int DW    = 8;   // data width
  parameter int NREG  = 8;   // data registers
  parameter int PDEP  = 32;  // program words
  parameter int IW    = 16;  // instruction width
  localparam int RAW  = $clog2(NREG);
  localparam int PAW  = $clog2(PDEP);
  localparam int OPW  = 3;

  typedef enum logic [OPW-1:0] {
    OP_MOV = 3'd0,
    OP_MVI = 3'd1,
    OP_ADD = 3'd2,
    OP_SUB = 3'd3,
    OP_BC  = 3'd4,
    OP_IN  = 3'd5,
    OP_OUT = 3'd6,
    OP_NOP = 3'd7
  } op_e;
endpackage

// File: rtl/mcu8_progmem.sv
module mcu8_progmem #(
  parameter int DEPTH = mcu8_pkg::PDEP,
  parameter int WIDTH = mcu8_pkg::IW,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mcu8_regfile.sv
module mcu8_regfile #(
  parameter int NREG = mcu8_pkg::NREG,
  parameter int DW   = mcu8_pkg::DW,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);
  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          regs_q[g] <= '0;
      else if (we && waddr == AW'(g))      regs_q[g] <= wdata;
    end
  end

  assign ra_data = regs_q[ra_addr];
  assign rb_data = regs_q[rb_addr];
endmodule

// File: rtl/mcu8_alu.sv
module mcu8_alu #(
  parameter int DW = mcu8_pkg::DW
) (
  input  logic          sub,
  input  logic [DW-1:0] dst_val,
  input  logic [DW-1:0] src_val,
  output logic [DW-1:0] result,
  output logic          cout
);
  logic [DW:0] wide;

  always_comb begin
    if (sub) wide = {1'b0, dst_val} - {1'b0, src_val};
    else     wide = {1'b0, dst_val} + {1'b0, src_val};
    result = wide[DW-1:0];
    cout   = wide[DW];
  end
endmodule

// File: rtl/mcu8_core.sv
module mcu8_core
  import mcu8_pkg::*;
#(
  parameter int W    = DW,
  parameter int NR   = NREG,
  parameter int PD   = PDEP,
  parameter int IWD  = IW,
  localparam int RA  = $clog2(NR),
  localparam int PA  = $clog2(PD)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_en,
  input  logic [PA-1:0]  load_addr,
  input  logic [IWD-1:0] load_word,
  input  logic [W-1:0]   din,
  output logic [W-1:0]   dout,
  output logic [PA-1:0]  pc_obs
);
  localparam int OP_HI  = IWD - 1;
  localparam int DST_HI = OP_HI - OPW;
  localparam int SRC_HI = DST_HI - RA;

  // reset release synchronizer
  logic [1:0] sync_q;
  logic       run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign run = sync_q[1];

  // state
  logic [PA-1:0]  pc_q, pc_d;
  logic           carry_q, carry_d;
  logic [W-1:0]   out_q, out_d;

  // decode
  logic [IWD-1:0] instr;
  op_e            op;
  logic [RA-1:0]  dst, src;
  logic [W-1:0]   imm;
  logic [PA-1:0]  off;
  logic [W-1:0]   dst_val, src_val, alu_res;
  logic           alu_cout;
  logic           rf_we;
  logic [W-1:0]   rf_wdata;

  mcu8_progmem #(.DEPTH(PD), .WIDTH(IWD)) u_pmem (
    .clk   (clk),
    .we    (load_en & ~run),
    .waddr (load_addr),
    .wdata (load_word),
    .raddr (pc_q),
    .rdata (instr)
  );

  assign op  = op_e'(instr[OP_HI -: OPW]);
  assign dst = instr[DST_HI -: RA];
  assign src = instr[SRC_HI -: RA];
  assign imm = instr[W-1:0];
  assign off = instr[PA-1:0];

  mcu8_regfile #(.NREG(NR), .DW(W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rf_we),
    .waddr   (dst),
    .wdata   (rf_wdata),
    .ra_addr (src),
    .ra_data (src_val),
    .rb_addr (dst),
    .rb_data (dst_val)
  );

  mcu8_alu #(.DW(W)) u_alu (
    .sub     (op == OP_SUB),
    .dst_val (dst_val),
    .src_val (src_val),
    .result  (alu_res),
    .cout    (alu_cout)
  );

  // next-state logic
  always_comb begin
    pc_d     = pc_q + PA'(1);
    carry_d  = carry_q;
    out_d    = out_q;
    rf_we    = 1'b0;
    rf_wdata = src_val;
    unique case (op)
      OP_MOV: rf_we = run;
      OP_MVI: begin rf_we = run; rf_wdata = imm; end
      OP_ADD, OP_SUB: begin
        rf_we    = run;
        rf_wdata = alu_res;
        carry_d  = alu_cout;
      end
      OP_BC:  if (carry_q) pc_d = pc_q + PA'(1) + off;
      OP_IN:  begin rf_we = run; rf_wdata = din; end
      OP_OUT: out_d = src_val;
      default: ;
    endcase
  end

  // registers with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      carry_q <= 1'b0;
      out_q   <= '0;
    end else if (run) begin
      pc_q    <= pc_d;
      carry_q <= carry_d;
      out_q   <= out_d;
    end
  end

  assign dout   = out_q;
  assign pc_obs = pc_q;
endmodule

// File: rtl/mcu8_checker.sv
module mcu8_checker #(
  parameter int W  = 8,
  parameter int PA = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic [2:0]    op,
  input logic [PA-1:0] off,
  input logic [PA-1:0] pc_q,
  input logic          carry_q,
  input logic [W-1:0]  src_val,
  input logic [W-1:0]  dout
);
  // R1: pc held at 0 until the synchronizer releases
  assert_hold_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pc_q == '0);

  // R10: straight-line code advances the pc by one, wrapping
  assert_pc_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op != 3'd4) |=> pc_q == $past(pc_q) + PA'(1));

  // R7: branch target when carry is set; R7: fall-through when clear
  assert_branch_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == 3'd4 && carry_q) |=> pc_q == $past(pc_q) + PA'(1) + $past(off));
  assert_branch_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == 3'd4 && !carry_q) |=> pc_q == $past(pc_q) + PA'(1));

  // R8: carry untouched except by add and subtract
  assert_carry_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || (op != 3'd2 && op != 3'd3)) |=> $stable(carry_q));

  // R9: output port loads the source on output, otherwise holds
  assert_out_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == 3'd6) |=> dout == $past(src_val));
  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || op != 3'd6) |=> $stable(dout));
endmodule

bind mcu8_core mcu8_checker #(.W(W), .PA(PA)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run     (run),
  .op      (instr[IWD-1 -: 3]),
  .off     (off),
  .pc_q    (pc_q),
  .carry_q (carry_q),
  .src_val (src_val),
  .dout    (dout)
);

// File: tb/sim_mcu8_core.sv
module sim_mcu8_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_en;
  logic [4:0]  load_addr;
  logic [15:0] load_word;
  logic [7:0]  din;
  logic [7:0]  dout;
  logic [4:0]  pc_obs;

  int nchk  = 0;
  int nfail = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  mcu8_core u0 (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .load_word(load_word), .din(din), .dout(dout), .pc_obs(pc_obs)
  );

  // program A: arithmetic, branches, I/O (R3 encoding)
  localparam logic [15:0] PROG_A [32] = '{
    16'h0000, 16'h24FF, 16'hC080, 16'h2801, 16'h4500, 16'hC080, 16'h6100, 16'hC000,
    16'hAC00, 16'hC180, 16'h3806, 16'h3405, 16'h5A80, 16'h8003, 16'hC300, 16'h7700,
    16'hC280, 16'h8002, 16'h3C77, 16'hC380, 16'hC380, 16'h1180, 16'hC200, 16'h8010,
    16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000
  };

  // vectors: {din, expected pc after edge, expected dout after edge}
  localparam logic [20:0] VEC [24] = '{
    {8'h00, 5'd1,  8'h00}, {8'h00, 5'd2,  8'h00}, {8'h00, 5'd3,  8'hFF}, // R4 R9
    {8'h00, 5'd4,  8'hFF}, {8'h00, 5'd5,  8'hFF}, {8'h00, 5'd6,  8'h00}, // R5 wrap
    {8'h00, 5'd7,  8'h00}, {8'h00, 5'd8,  8'hFF}, {8'h5A, 5'd9,  8'hFF}, // R6 borrow
    {8'h00, 5'd10, 8'h5A}, {8'h00, 5'd11, 8'h5A}, {8'h00, 5'd12, 8'h5A}, // R4 input
    {8'h00, 5'd13, 8'h5A}, {8'h00, 5'd14, 8'h5A}, {8'h00, 5'd15, 8'h0B}, // R7 not taken
    {8'h00, 5'd16, 8'h0B}, {8'h00, 5'd17, 8'hFA}, {8'h00, 5'd20, 8'hFA}, // R6 R7 taken
    {8'h00, 5'd21, 8'h00}, {8'h00, 5'd22, 8'h00}, {8'h00, 5'd23, 8'h5A}, // R1 R4 copy
    {8'h00, 5'd8,  8'h5A}, {8'hA5, 5'd9,  8'h5A}, {8'h00, 5'd10, 8'hA5}  // R7 R8 back
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_and_start(input logic [15:0] prog [32]);
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      load_en = 1'b1; load_addr = 5'(i); load_word = prog[i];
    end
    @(negedge clk);
    load_en = 1'b0;
    rst_n   = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 pc held during sync", 16'(pc_obs), 16'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      nfail++;
      $display("FAIL watchdog: actual %0d cycles expected finish", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] prog_b [32];
    rst_n = 1'b0; load_en = 1'b0; load_addr = '0; load_word = '0; din = '0;
    #2;
    check("R1 reset pc", 16'(pc_obs), 16'd0);
    check("R1 reset dout", 16'(dout), 16'd0);

    // table walk
    load_and_start(PROG_A);
    for (int v = 0; v < 24; v++) begin
      din = VEC[v][20:13];
      step();
      check($sformatf("R4-vector %0d pc", v), 16'(pc_obs), 16'(VEC[v][12:8]));
      check($sformatf("R9 vector %0d dout", v), 16'(dout), 16'(VEC[v][7:0]));
    end

    // R1: asynchronous clear mid-run
    #2 rst_n = 1'b0;
    #1;
    check("R1 async clear pc", 16'(pc_obs), 16'd0);
    check("R1 async clear dout", 16'(dout), 16'd0);

    // program B: add overflow carry, branch, ignored load, wrap
    for (int i = 0; i < 32; i++) prog_b[i] = 16'h0000;
    prog_b[0] = 16'h24C8;  // r1 = 200
    prog_b[1] = 16'h4480;  // r1 = r1 + r1 -> 0x90, carry
    prog_b[2] = 16'h8001;  // taken to 4
    prog_b[3] = 16'hC080;  // skipped
    load_and_start(prog_b);
    load_en = 1'b1; load_addr = 5'd5; load_word = 16'hC080;  // R2: must be ignored
    step();
    load_en = 1'b0;
    check("R10 pc after first", 16'(pc_obs), 16'd1);
    step();
    step();
    check("R5 add overflow sets carry so R7 branch taken", 16'(pc_obs), 16'd4);
    check("R7 skipped output", 16'(dout), 16'd0);
    for (int k = 0; k < 27; k++) step();
    check("R10 reaches 31", 16'(pc_obs), 16'd31);
    check("R2 load during run ignored", 16'(dout), 16'd0);
    step();
    check("R10 wrap to 0", 16'(pc_obs), 16'd0);
    step();
    check("R10 pc bit0 toggles", 16'(pc_obs[0]), 16'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule